// File: doc/BRIEF.md
# Dual-Port Word-Serial Configuration Loader

This block stores the per-channel settings of a sixteen-channel LED driver. It has three storage targets: a grayscale bank of sixteen 10-bit words, a dot-correction bank of sixteen 7-bit words, and one 10-bit brightness word. Each target has a shift chain that accepts one complete parallel word per load clock. A holding latch then passes the chain contents to the outputs. Each latch is level-sensitive: it follows its chain while its latch input is high and freezes while that input is low.

Port A has its own clock, an active-low enable, a 10-bit data bus, a latch input and a 10-bit cascade output. It can reach any of the three targets. Port B has a separate clock, a 7-bit data bus, a latch input and a 7-bit cascade output, and it serves dot correction only. Two select pins decide which target port A writes and which port owns dot correction. Each cascade output carries the last stage of its chain, so several devices can be chained word by word.

Top module: `cfg_loader`

## Requirements
- R1: With sel=2'b00 and aEnN low, each rising aClk edge shifts aData into the grayscale chain. After sixteen such edges, the first word loaded sits at channel 15 and the last at channel 0. gsOut channel i occupies bits [10i+9:10i].
- R2: With sel=2'b01 and aEnN low, one rising aClk edge fills the brightness chain with aData, and bcOut shows it once latched.
- R3: With sel=2'b10 and aEnN low, rising aClk edges shift aData[6:0] into the port A dot-correction chain. The upper data bits are dropped. dcOut channel i occupies bits [7i+6:7i].
- R4: While sel[1] is low, each rising bClk edge shifts bData into the port B dot-correction chain, for either value of sel[0].
- R5: Port A leaves every chain unchanged while aEnN is high, and also when sel=2'b11. A load into one target leaves the other port A chains unchanged.
- R6: While sel[1] is high, bClk edges leave the port B chain unchanged, and bLatch has no effect on dcOut.
- R7: aLatch high makes one latch transparent: gsOut when sel=2'b00, bcOut when sel=2'b01, and dcOut from the port A chain when sel=2'b10. bLatch high makes dcOut transparent to the port B chain while sel[1] is low. A latch whose input is low holds its value.
- R8: aOut shows the last stage of the port A target selected by sel: grayscale channel 15, the brightness word, or dot-correction channel 15 zero-extended. It is zero when sel=2'b11. bOut shows channel 15 of the port B chain.
- R9: While rst is high, the latched outputs read zero and every chain clears on its next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset |
| sel | input | 2 | Target and port select |
| aClk | input | 1 | Port A load clock |
| aEnN | input | 1 | Port A load enable, active low |
| aData | input | 10 | Port A parallel word |
| aLatch | input | 1 | Port A latch control, transparent when high |
| aOut | output | 10 | Port A cascade word |
| bClk | input | 1 | Port B load clock |
| bData | input | 7 | Port B parallel word |
| bLatch | input | 1 | Port B latch control, transparent when high |
| bOut | output | 7 | Port B cascade word |
| gsOut | output | 160 | Latched grayscale words, channel 0 in the low bits |
| dcOut | output | 112 | Latched dot-correction words, channel 0 in the low bits |
| bcOut | output | 10 | Latched brightness word |

## Verification
A shifted word reaches the chain, and so the cascade output, on the first rising load clock edge after it is presented. The latched outputs follow the chain in the same cycle that the latch input is raised, with no clock edge involved. The bench changes inputs only on falling aClk edges, and it pulses bClk by hand between aClk edges. Its monitor compares queued expectations 1.5 ns after a rising aClk edge, and only once the stimulus has stopped, so every register and latch on the path has settled by then.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [1:0] {
    TAP_GS   = 2'b00,
    TAP_BC   = 2'b01,
    TAP_DC   = 2'b10,
    TAP_NONE = 2'b11
  } tap_e;

  typedef struct packed {
    logic shiftGs;
    logic shiftBc;
    logic shiftDcA;
    logic shiftDcB;
    logic openGs;
    logic openBc;
    logic openDc;
    logic dcFromA;
    tap_e aTap;
  } ctrl_strobes_t;

endpackage

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int W = 10,
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shiftEn,
  input  logic [W-1:0]   din,
  output logic [N*W-1:0] words,
  output logic [W-1:0]   tail
);
  logic [W-1:0] stage [N];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else if (shiftEn) stage[0] <= din;
  end

  for (genvar i = 1; i < N; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else if (shiftEn) stage[i] <= stage[i-1];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_flat
    assign words[i*W +: W] = stage[i];
  end

  assign tail = stage[N-1];
endmodule

// File: rtl/word_latch.sv
module word_latch #(
  parameter int W = 10
) (
  input  logic         rst,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (rst) q = '0;
    else if (open) q = d;
  end
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_loader_pkg::*;
(
  input  logic [1:0]    sel,
  input  logic          aEnN,
  input  logic          aLatch,
  input  logic          bLatch,
  output ctrl_strobes_t strb
);
  tap_e tap;

  always_comb begin
    tap = tap_e'(sel);
    strb.aTap     = tap;
    strb.shiftGs  = !aEnN && (tap == TAP_GS);
    strb.shiftBc  = !aEnN && (tap == TAP_BC);
    strb.shiftDcA = !aEnN && (tap == TAP_DC);
    strb.shiftDcB = !sel[1];
    strb.openGs   = aLatch && (tap == TAP_GS);
    strb.openBc   = aLatch && (tap == TAP_BC);
    strb.openDc   = (aLatch && (tap == TAP_DC)) || (bLatch && !sel[1]);
    strb.dcFromA  = sel[1];
  end
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cfg_loader_pkg::*;
#(
  parameter int CH   = 16,
  parameter int GS_W = 10,
  parameter int DC_W = 7,
  parameter int BC_W = 10
) (
  input  logic             rst,
  input  logic             aClk,
  input  logic             bClk,
  input  ctrl_strobes_t    strb,
  input  logic [GS_W-1:0]  aData,
  input  logic [DC_W-1:0]  bData,
  output logic [GS_W-1:0]  aOut,
  output logic [DC_W-1:0]  bOut,
  output logic [CH*GS_W-1:0] gsOut,
  output logic [CH*DC_W-1:0] dcOut,
  output logic [BC_W-1:0]  bcOut
);
  localparam int GS_BITS = CH * GS_W;
  localparam int DC_BITS = CH * DC_W;

  logic [GS_BITS-1:0] gsWords;
  logic [DC_BITS-1:0] dcAWords, dcBWords;
  logic [BC_W-1:0]    bcWord;
  logic [GS_W-1:0]    gsTail;
  logic [DC_W-1:0]    dcATail, dcBTail;
  logic [BC_W-1:0]    bcTail;

  word_shifter #(.W(GS_W), .N(CH)) u_gsChain (
    .clk(aClk), .rst(rst), .shiftEn(strb.shiftGs), .din(aData),
    .words(gsWords), .tail(gsTail));

  word_shifter #(.W(BC_W), .N(1)) u_bcChain (
    .clk(aClk), .rst(rst), .shiftEn(strb.shiftBc), .din(aData[BC_W-1:0]),
    .words(bcWord), .tail(bcTail));

  word_shifter #(.W(DC_W), .N(CH)) u_dcAChain (
    .clk(aClk), .rst(rst), .shiftEn(strb.shiftDcA), .din(aData[DC_W-1:0]),
    .words(dcAWords), .tail(dcATail));

  word_shifter #(.W(DC_W), .N(CH)) u_dcBChain (
    .clk(bClk), .rst(rst), .shiftEn(strb.shiftDcB), .din(bData),
    .words(dcBWords), .tail(dcBTail));

  word_latch #(.W(GS_BITS)) u_gsHold (
    .rst(rst), .open(strb.openGs), .d(gsWords), .q(gsOut));

  word_latch #(.W(BC_W)) u_bcHold (
    .rst(rst), .open(strb.openBc), .d(bcWord), .q(bcOut));

  word_latch #(.W(DC_BITS)) u_dcHold (
    .rst(rst), .open(strb.openDc),
    .d(strb.dcFromA ? dcAWords : dcBWords), .q(dcOut));

  always_comb begin
    aOut = '0;
    unique case (strb.aTap)
      TAP_GS:  aOut = gsTail;
      TAP_BC:  aOut[BC_W-1:0] = bcTail;
      TAP_DC:  aOut[DC_W-1:0] = dcATail;
      default: aOut = '0;
    endcase
  end

  assign bOut = dcBTail;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int CH   = 16,
  parameter int GS_W = 10,
  parameter int DC_W = 7,
  parameter int BC_W = 10
) (
  input  logic               rst,
  input  logic [1:0]         sel,
  input  logic               aClk,
  input  logic               aEnN,
  input  logic [GS_W-1:0]    aData,
  input  logic               aLatch,
  output logic [GS_W-1:0]    aOut,
  input  logic               bClk,
  input  logic [DC_W-1:0]    bData,
  input  logic               bLatch,
  output logic [DC_W-1:0]    bOut,
  output logic [CH*GS_W-1:0] gsOut,
  output logic [CH*DC_W-1:0] dcOut,
  output logic [BC_W-1:0]    bcOut
);
  ctrl_strobes_t strb;

  cfg_ctrl u_ctrl (
    .sel(sel), .aEnN(aEnN), .aLatch(aLatch), .bLatch(bLatch), .strb(strb));

  cfg_datapath #(.CH(CH), .GS_W(GS_W), .DC_W(DC_W), .BC_W(BC_W)) u_dp (
    .rst(rst), .aClk(aClk), .bClk(bClk), .strb(strb),
    .aData(aData), .bData(bData), .aOut(aOut), .bOut(bOut),
    .gsOut(gsOut), .dcOut(dcOut), .bcOut(bcOut));
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int CH   = 16,
  parameter int GS_W = 10,
  parameter int DC_W = 7,
  parameter int BC_W = 10
) (
  input logic               rst,
  input logic [1:0]         sel,
  input logic               aClk,
  input logic               aEnN,
  input logic [GS_W-1:0]    aData,
  input logic               aLatch,
  input logic [GS_W-1:0]    aOut,
  input logic               bClk,
  input logic               bLatch,
  input logic [DC_W-1:0]    bOut,
  input logic [CH*GS_W-1:0] gsOut,
  input logic [CH*DC_W-1:0] dcOut
);
  AST_BC_ONE_LOAD: assert property (@(posedge aClk) disable iff (rst)
    (sel == 2'b01 && !aEnN) |=> (sel != 2'b01 || aOut == $past(aData))); // R2

  AST_A_IDLE_HOLDS: assert property (@(posedge aClk) disable iff (rst)
    (!$past(rst) && $past(aEnN) && $stable(sel)) |-> $stable(aOut)); // R5

  AST_B_DESELECTED: assert property (@(posedge bClk) disable iff (rst)
    (!$past(rst) && $past(sel[1])) |-> $stable(bOut)); // R6

  AST_GS_LATCH_HOLD: assert property (@(posedge aClk) disable iff (rst)
    (!$past(rst) && !aLatch && !$past(aLatch)) |-> $stable(gsOut)); // R7

  AST_DC_LATCH_HOLD: assert property (@(posedge aClk) disable iff (rst)
    (!$past(rst) && !aLatch && !$past(aLatch) && !bLatch && !$past(bLatch))
      |-> $stable(dcOut)); // R7

  AST_A_TAP_NONE: assert property (@(posedge aClk) disable iff (rst)
    (sel == 2'b11) |-> (aOut == '0)); // R8
endmodule

bind cfg_loader cfg_loader_chk #(.CH(CH), .GS_W(GS_W), .DC_W(DC_W), .BC_W(BC_W)) u_chk (
  .rst(rst), .sel(sel), .aClk(aClk), .aEnN(aEnN), .aData(aData),
  .aLatch(aLatch), .aOut(aOut), .bClk(bClk), .bLatch(bLatch), .bOut(bOut),
  .gsOut(gsOut), .dcOut(dcOut));

// File: tb/cfg_loader_bench.sv
`timescale 1ns/100ps
module cfg_loader_bench;
  localparam int CH = 16;

  logic rst = 1'b1, aClk = 1'b0, aEnN = 1'b1, aLatch = 1'b0;
  logic bClk = 1'b0, bLatch = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [9:0] aData = '0;
  logic [6:0] bData = '0;
  logic [9:0] aOut, bcOut;
  logic [6:0] bOut;
  logic [CH*10-1:0] gsOut;
  logic [CH*7-1:0]  dcOut;

  cfg_loader u_cfg_loader (
    .rst(rst), .sel(sel), .aClk(aClk), .aEnN(aEnN), .aData(aData),
    .aLatch(aLatch), .aOut(aOut), .bClk(bClk), .bData(bData),
    .bLatch(bLatch), .bOut(bOut), .gsOut(gsOut), .dcOut(dcOut), .bcOut(bcOut));

  always #2 aClk = ~aClk;

  // reference state, built from the requirements
  logic [9:0] gsSr [CH];
  logic [6:0] dcASr [CH];
  logic [6:0] dcBSr [CH];
  logic [9:0] bcSr;
  logic [9:0] gsL [CH];
  logic [6:0] dcL [CH];
  logic [9:0] bcL;

  typedef struct {
    string req;
    int kind;
    int idx;
    logic [9:0] exp;
  } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [9:0] expAOut();
    case (sel)
      2'b00: return gsSr[CH-1];
      2'b01: return bcSr;
      2'b10: return {3'b000, dcASr[CH-1]};
      default: return '0;
    endcase
  endfunction

  task automatic push(string req, int kind, int idx, logic [9:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.idx = idx; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic checkAll(string req);
    for (int i = 0; i < CH; i++) push(req, 0, i, gsL[i]);
    for (int i = 0; i < CH; i++) push(req, 1, i, {3'b000, dcL[i]});
    push(req, 2, 0, bcL);
    push(req, 3, 0, expAOut());
    push(req, 4, 0, {3'b000, dcBSr[CH-1]});
    wait (sb.size() == 0);
    @(negedge aClk);
  endtask

  // monitor: pops expectations after the outputs have settled
  initial begin
    forever begin
      @(posedge aClk);
      #1.5;
      while (sb.size() > 0) begin
        item_t it;
        logic [9:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = gsOut[it.idx*10 +: 10];
          1: act = {3'b000, dcOut[it.idx*7 +: 7]};
          2: act = bcOut;
          3: act = aOut;
          default: act = {3'b000, bOut};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d ch=%0d actual=%h expected=%h",
                   it.req, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  // driver tasks, entered and left at a falling aClk edge
  task automatic aShift(logic [9:0] w);
    aData = w;
    aEnN = 1'b0;
    @(negedge aClk);
    aEnN = 1'b1;
    if (sel == 2'b00) begin
      for (int i = CH-1; i > 0; i--) gsSr[i] = gsSr[i-1];
      gsSr[0] = w;
    end else if (sel == 2'b01) begin
      bcSr = w;
    end else if (sel == 2'b10) begin
      for (int i = CH-1; i > 0; i--) dcASr[i] = dcASr[i-1];
      dcASr[0] = w[6:0];
    end
  endtask

  task automatic bShift(logic [6:0] w);
    bData = w;
    #0.5 bClk = 1'b1;
    #0.5 bClk = 1'b0;
    if (!sel[1]) begin
      for (int i = CH-1; i > 0; i--) dcBSr[i] = dcBSr[i-1];
      dcBSr[0] = w;
    end
    @(negedge aClk);
  endtask

  task automatic pulseA();
    aLatch = 1'b1;
    @(negedge aClk);
    aLatch = 1'b0;
    if (sel == 2'b00) for (int i = 0; i < CH; i++) gsL[i] = gsSr[i];
    else if (sel == 2'b01) bcL = bcSr;
    else if (sel == 2'b10) for (int i = 0; i < CH; i++) dcL[i] = dcASr[i];
  endtask

  task automatic pulseB();
    bLatch = 1'b1;
    @(negedge aClk);
    bLatch = 1'b0;
    if (!sel[1]) for (int i = 0; i < CH; i++) dcL[i] = dcBSr[i];
  endtask

  task automatic clearModel();
    for (int i = 0; i < CH; i++) begin
      gsSr[i] = '0; dcASr[i] = '0; dcBSr[i] = '0; gsL[i] = '0; dcL[i] = '0;
    end
    bcSr = '0; bcL = '0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    #0.5 bClk = 1'b1;
    #0.5 bClk = 1'b0;
    @(negedge aClk);
    @(negedge aClk);
    rst = 1'b0;
    clearModel();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired R9 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge aClk);
    doReset();
    checkAll("R9");

    // grayscale fill, latch still closed
    sel = 2'b00;
    for (int k = 0; k < CH; k++) aShift(10'((k * 37 + 5) % 1024));
    checkAll("R7");
    pulseA();
    checkAll("R1");

    // enable high: data wiggles, nothing moves
    for (int k = 0; k < 4; k++) begin
      aData = 10'(k * 91 + 3);
      @(negedge aClk);
    end
    checkAll("R5");

    // one more grayscale word with latch closed: output held, tap moves
    aShift(10'h3C1);
    checkAll("R7");

    // brightness, one load
    sel = 2'b01;
    aShift(10'h2A5);
    checkAll("R2");
    pulseA();
    checkAll("R2");

    // dot correction through port A, upper data bits dropped
    sel = 2'b10;
    for (int k = 0; k < CH; k++) aShift(10'(10'h380 | ((k * 11 + 2) % 128)));
    pulseA();
    checkAll("R3");

    // grayscale chain untouched by the other loads
    sel = 2'b00;
    checkAll("R8");

    // sel=11: port A idle, tap reads zero, latch opens nothing
    sel = 2'b11;
    aShift(10'h155);
    aShift(10'h0AA);
    pulseA();
    checkAll("R5");

    // port B dot correction, sel[0] low
    sel = 2'b00;
    for (int k = 0; k < CH; k++) bShift(7'((k * 23 + 9) % 128));
    checkAll("R8");
    pulseB();
    checkAll("R4");

    // port B with sel[0] high
    sel = 2'b01;
    for (int k = 0; k < 3; k++) bShift(7'(k * 40 + 17));
    pulseB();
    checkAll("R4");

    // port B deselected: clock and latch have no effect
    sel = 2'b10;
    for (int k = 0; k < 3; k++) bShift(7'(k * 13 + 100));
    checkAll("R6");
    pulseB();
    checkAll("R6");
    pulseA();
    checkAll("R3");

    // reset in mid-run
    doReset();
    checkAll("R9");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule